// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block manages the settling interval of a codec's two data paths when they are powered up: the record path (left and right ADC) and the playback path (DAC). It watches three enable bits from a control register. When a path turns on while the other path is still off, it runs a settling interval. The interval is counted in sample periods, using a one-cycle strobe that marks each sample. If the other path is already on, no interval is needed and data flows at once.

While a path is settling, both of its channels are replaced by two's-complement zero. For the record path this applies to the samples leaving the block. For the playback path it applies to the samples on their way to the converter. Each path has a flag that is high during its interval. An active-low power-down input clears all control state.

Top module: `cvt_init_seq`

## Requirements
- R1: When either record enable (left or right) goes from 0 to 1 while the playback enable is 0, `adc_init` is 1 from the next clock cycle.
- R2: When the playback enable goes from 0 to 1 while both record enables are 0, `dac_init` is 1 from the next clock cycle.
- R3: An interval counts only the cycles in which `fs_tick` is 1, and lasts INIT_LEN (default 1059) such ticks. The flag is 0 from the cycle after the INIT_LEN-th tick. A tick in the same cycle as the start is not counted.
- R4: While `adc_init` is 1, `adc_out_l` and `adc_out_r` are both 0.
- R5: While `dac_init` is 1, `dac_out_l` and `dac_out_r` are both 0.
- R6: A path whose enable rises while the other path is enabled starts no interval: its flag stays 0 and its data passes through.
- R7: If all of a path's own enables are 0 during its interval, the interval ends and the flag is 0 from the next cycle.
- R8: A 0-to-1 enable edge on a path whose interval is already running does not restart the count.
- R9: While `rst_n` is 0, both flags are 0 and any running interval is discarded. After reset with all enables at 0, both flags are 0.
- R10: When a path's flag is 0, its outputs equal its inputs bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-down/reset |
| fs_tick | input | 1 | One-cycle strobe once per sample period |
| en_adc_l | input | 1 | Left record path enable |
| en_adc_r | input | 1 | Right record path enable |
| en_dac | input | 1 | Playback path enable |
| adc_raw_l | input | DATA_W | Left sample from record converter |
| adc_raw_r | input | DATA_W | Right sample from record converter |
| dac_in_l | input | DATA_W | Left playback sample |
| dac_in_r | input | DATA_W | Right playback sample |
| adc_out_l | output | DATA_W | Left record sample after zero forcing |
| adc_out_r | output | DATA_W | Right record sample after zero forcing |
| dac_out_l | output | DATA_W | Left playback sample to converter |
| dac_out_r | output | DATA_W | Right playback sample to converter |
| adc_init | output | 1 | Record path settling flag |
| dac_init | output | 1 | Playback path settling flag |

## Verification
Two events can land in the same cycle: the start of an interval and a sample strobe. The bench raises the playback enable in the very cycle that `fs_tick` is high. The start must win, and the strobe must not be counted. The judgement is that the flag is still high after 1058 further strobes and low after exactly 1059.

// File: rtl/cis_pkg.sv
package cis_pkg;

  // Number of bits needed to hold a count up to len
  function automatic int cnt_bits(input int len);
    return $clog2(len + 1);
  endfunction

  // Remaining-count update for one counted sample strobe
  function automatic logic [31:0] cnt_dec(input logic [31:0] cnt);
    return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction

  // True when the strobe being counted is the final one
  function automatic logic cnt_last(input logic [31:0] cnt);
    return cnt == 32'd1;
  endfunction

endpackage

// File: rtl/cis_edge.sv
module cis_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/cis_period.sv
module cis_period #(
  parameter int LEN   = 1059,
  parameter int CNT_W = cis_pkg::cnt_bits(LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic busy
);
  import cis_pkg::*;

  localparam logic [31:0] LEN32 = 32'(LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [31:0]      cnt_ext;

  assign cnt_ext = 32'(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort && busy_q) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LEN32[CNT_W-1:0];
    end else if (busy_q && tick) begin
      busy_q <= !cnt_last(cnt_ext);
      cnt_q  <= CNT_W'(cnt_dec(cnt_ext));
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cis_zero_mux.sv
module cis_zero_mux #(
  parameter int DATA_W = 16,
  parameter int NCH    = 2
) (
  input  logic                   force_zero,
  input  logic [NCH-1:0][DATA_W-1:0] din,
  output logic [NCH-1:0][DATA_W-1:0] dout
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dout[c] = force_zero ? '0 : din[c];
  end
endmodule

// File: rtl/cvt_init_seq.sv
module cvt_init_seq #(
  parameter int DATA_W   = 16,
  parameter int INIT_LEN = 1059
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic              en_adc_l,
  input  logic              en_adc_r,
  input  logic              en_dac,
  input  logic [DATA_W-1:0] adc_raw_l,
  input  logic [DATA_W-1:0] adc_raw_r,
  input  logic [DATA_W-1:0] dac_in_l,
  input  logic [DATA_W-1:0] dac_in_r,
  output logic [DATA_W-1:0] adc_out_l,
  output logic [DATA_W-1:0] adc_out_r,
  output logic [DATA_W-1:0] dac_out_l,
  output logic [DATA_W-1:0] dac_out_r,
  output logic              adc_init,
  output logic              dac_init
);
  localparam int NEN   = 3;
  localparam int CNT_W = cis_pkg::cnt_bits(INIT_LEN);

  // enable vector: [0] left record, [1] right record, [2] playback
  logic [NEN-1:0] en_vec;
  logic [NEN-1:0] en_rise;
  logic adc_rise, dac_rise;
  logic adc_any, adc_start, dac_start, adc_abort, dac_abort;

  assign en_vec = {en_dac, en_adc_r, en_adc_l};

  cis_edge #(.N(NEN)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(en_vec), .rise(en_rise)
  );

  assign adc_any   = en_adc_l | en_adc_r;
  assign adc_rise  = en_rise[0] | en_rise[1];
  assign dac_rise  = en_rise[2];
  assign adc_start = adc_rise & ~en_dac;
  assign dac_start = dac_rise & ~adc_any;
  assign adc_abort = ~adc_any;
  assign dac_abort = ~en_dac;

  cis_period #(.LEN(INIT_LEN), .CNT_W(CNT_W)) u_adc_per (
    .clk(clk), .rst_n(rst_n), .start(adc_start), .abort(adc_abort),
    .tick(fs_tick), .busy(adc_init)
  );

  cis_period #(.LEN(INIT_LEN), .CNT_W(CNT_W)) u_dac_per (
    .clk(clk), .rst_n(rst_n), .start(dac_start), .abort(dac_abort),
    .tick(fs_tick), .busy(dac_init)
  );

  logic [1:0][DATA_W-1:0] adc_in_v, adc_out_v, dac_in_v, dac_out_v;
  assign adc_in_v = {adc_raw_r, adc_raw_l};
  assign dac_in_v = {dac_in_r, dac_in_l};

  cis_zero_mux #(.DATA_W(DATA_W), .NCH(2)) u_adc_mux (
    .force_zero(adc_init), .din(adc_in_v), .dout(adc_out_v)
  );

  cis_zero_mux #(.DATA_W(DATA_W), .NCH(2)) u_dac_mux (
    .force_zero(dac_init), .din(dac_in_v), .dout(dac_out_v)
  );

  assign adc_out_l = adc_out_v[0];
  assign adc_out_r = adc_out_v[1];
  assign dac_out_l = dac_out_v[0];
  assign dac_out_r = dac_out_v[1];
endmodule

// File: rtl/cis_chk.sv
module cis_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_tick,
  input logic              en_adc_l,
  input logic              en_adc_r,
  input logic              en_dac,
  input logic              adc_start,
  input logic              dac_start,
  input logic              adc_init,
  input logic              dac_init,
  input logic [DATA_W-1:0] adc_out_l,
  input logic [DATA_W-1:0] adc_out_r,
  input logic [DATA_W-1:0] dac_out_l,
  input logic [DATA_W-1:0] dac_out_r
);
  // R1
  adc_start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> adc_init);

  // R2
  dac_start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_start |=> dac_init);

  // R3
  adc_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_init && !fs_tick && (en_adc_l || en_adc_r)) |=> adc_init);

  // R3
  dac_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_init && !fs_tick && en_dac) |=> dac_init);

  // R4
  adc_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_init |-> (adc_out_l == '0 && adc_out_r == '0));

  // R5
  dac_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_init |-> (dac_out_l == '0 && dac_out_r == '0));

  // R6
  adc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_init && en_dac) |=> !adc_init);

  // R6
  dac_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_init && (en_adc_l || en_adc_r)) |=> !dac_init);

  // R7
  adc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_init && !en_adc_l && !en_adc_r) |=> !adc_init);

  // R7
  dac_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_init && !en_dac) |=> !dac_init);
endmodule

bind cvt_init_seq cis_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick),
  .en_adc_l(en_adc_l), .en_adc_r(en_adc_r), .en_dac(en_dac),
  .adc_start(adc_start), .dac_start(dac_start),
  .adc_init(adc_init), .dac_init(dac_init),
  .adc_out_l(adc_out_l), .adc_out_r(adc_out_r),
  .dac_out_l(dac_out_l), .dac_out_r(dac_out_r)
);

// File: tb/cvt_init_seq_tb.sv
module cvt_init_seq_tb;
  localparam int DW  = 16;
  localparam int LEN = 1059;

  localparam logic [DW-1:0] AL = 16'h1234, AR = 16'h8001;
  localparam logic [DW-1:0] DL = 16'h7FFF, DR = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0, fs_tick = 1'b0;
  logic en_adc_l = 1'b0, en_adc_r = 1'b0, en_dac = 1'b0;
  logic [DW-1:0] adc_out_l, adc_out_r, dac_out_l, dac_out_r;
  logic adc_init, dac_init;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cvt_init_seq #(.DATA_W(DW), .INIT_LEN(LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick),
    .en_adc_l(en_adc_l), .en_adc_r(en_adc_r), .en_dac(en_dac),
    .adc_raw_l(AL), .adc_raw_r(AR), .dac_in_l(DL), .dac_in_r(DR),
    .adc_out_l(adc_out_l), .adc_out_r(adc_out_r),
    .dac_out_l(dac_out_l), .dac_out_r(dac_out_r),
    .adc_init(adc_init), .dac_init(dac_init)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      fs_tick = 1'b1; @(negedge clk);
      fs_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic set_en(input logic [2:0] v);
    {en_adc_l, en_adc_r, en_dac} = v;
    step(2);
  endtask

  // expected outputs for a flag pair, rule R4/R5/R10
  task automatic check_data(input string req, input logic ea, input logic ed);
    check(req, {adc_out_l, adc_out_r, dac_out_l, dac_out_r},
          {ea ? 16'h0 : AL, ea ? 16'h0 : AR, ed ? 16'h0 : DL, ed ? 16'h0 : DR});
  endtask

  // {pre{l,r,dac}, post{l,r,dac}, exp adc_init, exp dac_init}
  localparam logic [7:0] VEC [8] = '{
    {3'b000, 3'b100, 2'b10},  // R1 left
    {3'b000, 3'b010, 2'b10},  // R1 right
    {3'b000, 3'b001, 2'b01},  // R2
    {3'b001, 3'b101, 2'b01},  // R6 record blocked by playback
    {3'b100, 3'b101, 2'b10},  // R6 playback blocked by record
    {3'b000, 3'b111, 2'b00},  // R6 simultaneous
    {3'b000, 3'b110, 2'b10},  // R1 both record
    {3'b100, 3'b000, 2'b00}   // R7 abort
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    // R9 reset state
    check("R9 flags in reset", {adc_init, dac_init}, 2'b00);
    rst_n = 1'b1;
    step(2);
    check("R9 flags after reset", {adc_init, dac_init}, 2'b00);
    check_data("R10 pass-through idle", 1'b0, 1'b0);

    for (int i = 0; i < 8; i++) begin
      set_en(3'b000);
      set_en(VEC[i][7:5]);
      set_en(VEC[i][4:2]);
      check($sformatf("R1/R2/R6/R7 vec%0d flags", i), {adc_init, dac_init}, VEC[i][1:0]);
      check_data($sformatf("R4/R5/R10 vec%0d data", i), VEC[i][1], VEC[i][0]);
    end

    // R3 exact length, record path
    set_en(3'b000);
    set_en(3'b100);
    ticks(LEN - 1);
    check("R3 adc still busy before last tick", adc_init, 1'b1);
    check_data("R4 zero before last tick", 1'b1, 1'b0);
    ticks(1);
    check("R3 adc done after last tick", adc_init, 1'b0);
    check_data("R10 record passes after period", 1'b0, 1'b0);

    // R3 tick coinciding with start is not counted
    set_en(3'b000);
    en_dac = 1'b1; fs_tick = 1'b1;
    step(1);
    fs_tick = 1'b0;
    step(1);
    ticks(LEN - 1);
    check("R3 coincident tick ignored", dac_init, 1'b1);
    ticks(1);
    check("R3 dac done after full count", dac_init, 1'b0);

    // R8 second edge does not restart
    set_en(3'b000);
    set_en(3'b100);
    ticks(500);
    set_en(3'b110);
    check("R8 still busy after second edge", adc_init, 1'b1);
    ticks(LEN - 501);
    check("R8 busy before original end", adc_init, 1'b1);
    ticks(1);
    check("R8 ends at original count", adc_init, 1'b0);

    // R9 reset mid-period
    set_en(3'b000);
    set_en(3'b001);
    ticks(10);
    rst_n = 1'b0;
    step(1);
    check("R9 reset clears running period", {adc_init, dac_init}, 2'b00);
    {en_adc_l, en_adc_r, en_dac} = 3'b000;
    step(1);
    rst_n = 1'b1;
    step(2);
    check("R9 idle after reset release", {adc_init, dac_init}, 2'b00);
    check_data("R10 pass after reset", 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule